// File: doc/BRIEF.md
# Quad DAC Double-Buffered Register Interface

This block is the digital front end for a four-channel, 12-bit voltage-output converter. One parallel port serves a host processor for both writes and readback. Each channel keeps a first-rank input register and a second-rank converter register. The host fills the input registers one at a time, and a single load strobe then moves all four into their converter registers on the same clock edge, so the four outputs step together. A per-channel range register chooses unipolar or bipolar coding and a gain of one or two. The block presents that range to the analog side, and the host can read it back.

The host may write a channel in 4-bit or 8-bit pieces or as one 12-bit word. Readback works the same way, from either rank of any channel or from the range register. The readback bus floats unless a read is under way. A pass-through mode lets written data reach the converter code on the same edge that writes the input rank. It can be enabled for one chosen channel or for all four. A zero override input acts without the clock. It forces every converter code to the code that means zero volts for that channel's range. It leaves both register ranks intact, so releasing the override brings back the previous output.

Top module: `quad_dac_frontend`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, every input rank, converter rank and range register clears to zero. After reset, `dac_code` reads 0, `mode_bip` and `mode_gain2` read 0, and every readback returns 0.
- R2: A write with `cs`=1, `wr`=1, `sel[2]`=0 and `wsize`=2 or 3 stores `din` into the input rank of channel `sel[1:0]` at that edge. Other channels are untouched, and no converter code changes unless a load or pass-through applies.
- R3: A partial write places data taken from the low end of `din` into part of the input rank. With `wsize`=0 (nibble) it goes to bits [4k+3:4k]. With `wsize`=1 (byte) it goes to bits [4k+7:4k], clipped at bit 11. Here k is `slice`. All other bits keep their values, and a nibble write with k=3 changes nothing.
- R4: A cycle with `ldac`=1 copies each channel's input rank into its converter rank at that edge, and all four codes change on the same edge. The copy includes any write made on that same edge. With no load, no pass-through and no write, the codes hold.
- R5: With `xparent`=1 and `xp_all`=0, channel `xp_ch` copies its input rank, including a same-edge write, into its converter rank on every edge. The other channels keep waiting for a load.
- R6: With `xparent`=1 and `xp_all`=1, all four channels pass through as in R5.
- R7: A write with `sel[2]`=1 loads the range register from `din[7:0]`, whatever the values of `wsize` and `slice`. Bit 2i sets bipolar for channel i and bit 2i+1 sets gain two. These bits appear on `mode_bip[i]` and `mode_gain2[i]` after the edge.
- R8: While `zero_n`=0, without waiting for a clock, each channel's code is 0x000 if unipolar and 0x800 if bipolar. Both ranks keep their contents, and after release the code returns to the converter rank value.
- R9: With `cs`=1 and `rd`=1, the read value is driven onto `rd_bus` and `rd_oe`=1. The source is the range register (zero-extended) when `sel[2]`=1. Otherwise it is channel `sel[1:0]`'s input rank (`rd_rank`=0) or converter rank (`rd_rank`=1), cut as follows: nibble k at the low 4 bits, byte k (bits [4k+7:4k]) at the low 8 bits, or the full word.
- R10: When `cs` and `rd` are not both 1, `rd_oe`=0 and `rd_bus` is high impedance.
- R11: When `cs`=0 or `wr`=0, no register changes, whatever `din`, `sel`, `wsize` and `slice` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, qualifies writes and reads |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read enable |
| sel | input | 3 | [1:0] channel, [2] selects the range register |
| wsize | input | 2 | Transfer size: 0 nibble, 1 byte, 2/3 word |
| slice | input | 2 | Nibble index k for partial transfers |
| din | input | 12 | Write data, right-aligned |
| rd_rank | input | 1 | Readback source: 0 input rank, 1 converter rank |
| ldac | input | 1 | Load all converter ranks from input ranks |
| xparent | input | 1 | Pass-through enable |
| xp_all | input | 1 | Pass-through applies to all channels |
| xp_ch | input | 2 | Pass-through channel when `xp_all`=0 |
| zero_n | input | 1 | Active-low zero-volt override, unclocked |
| dac_code | output | 48 | Converter codes, channel i at [12i+11:12i] |
| mode_bip | output | 4 | Per-channel bipolar range |
| mode_gain2 | output | 4 | Per-channel gain-of-two range |
| rd_oe | output | 1 | Readback bus driven |
| rd_bus | output | 12 | Tristate readback data |

## Verification
A wrong input-rank bit cannot be seen at the converter codes until a load or pass-through. The bench therefore reads back both ranks through the port at random points, so a corrupted slice shows up on the very next read instead of hiding. Converter-rank and range faults reach `dac_code` or `mode_*` one edge after the write or load that causes them, and the model compares all four codes after every operation. A fault in the zero override is visible at once, with no clock. A fault that failed to keep the ranks intact appears after release, as a code that does not return to its previous value.

// File: rtl/qdf_pkg.sv
// Shared types for the quad DAC front end.
// Assumes a transfer-size field of two bits and a two-bit range entry per channel.
package qdf_pkg;

    typedef enum logic [1:0] {
        XW_NIB  = 2'd0,
        XW_BYTE = 2'd1,
        XW_WORD = 2'd2,
        XW_WALT = 2'd3
    } xfer_w_e;

    // One channel's range entry; bit 0 bipolar, bit 1 gain of two.
    typedef struct packed {
        logic gain2;
        logic bip;
    } ch_mode_t;

endpackage

// File: rtl/qdf_wr_decode.sv
// Write decoder: turns a qualified host write into per-channel enables,
// a range-register enable, and a bit mask with aligned data for partial writes.
// Assumes DW > 2*SW so that byte masks fit inside the word.
module qdf_wr_decode #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    parameter int SW  = 4,
    localparam int CHW = $clog2(NCH),
    localparam int SLW = $clog2(DW / SW + 1)
) (
    input  logic           cs,
    input  logic           wr,
    input  logic [CHW:0]   sel,
    input  logic [1:0]     wsize,
    input  logic [SLW-1:0] slice,
    input  logic [DW-1:0]  din,
    output logic [NCH-1:0] ch_we,
    output logic           mode_we,
    output logic [DW-1:0]  wmask,
    output logic [DW-1:0]  wdata
);
    import qdf_pkg::*;

    localparam logic [DW-1:0] NIB_ONES  = {{(DW-SW){1'b0}}, {SW{1'b1}}};
    localparam logic [DW-1:0] BYTE_ONES = {{(DW-2*SW){1'b0}}, {(2*SW){1'b1}}};

    logic wr_hit;
    int   shamt;

    assign wr_hit  = cs && wr;
    assign mode_we = wr_hit && sel[CHW];

    // Per-channel write enables from the channel field.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ch_we[i] = wr_hit && !sel[CHW] && (sel[CHW-1:0] == CHW'(i));
        end
    end

    // Mask and aligned data for the transfer size and slice.
    always_comb begin
        shamt = SW * int'(slice);
        case (xfer_w_e'(wsize))
            XW_NIB: begin
                wmask = NIB_ONES << shamt;
                wdata = (din & NIB_ONES) << shamt;
            end
            XW_BYTE: begin
                wmask = BYTE_ONES << shamt;
                wdata = (din & BYTE_ONES) << shamt;
            end
            default: begin
                wmask = '1;
                wdata = din;
            end
        endcase
    end

endmodule

// File: rtl/qdf_channel.sv
// One converter channel: input rank, converter rank and the zero override.
// The converter rank captures the post-write input value on load or pass-through.
// Assumes the override input may change at any time; its effect is combinational.
module qdf_channel #(
    parameter int DW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DW-1:0]     wmask,
    input  logic [DW-1:0]     wdata,
    input  logic              load,
    input  logic              xp,
    input  logic              zero_n,
    input  qdf_pkg::ch_mode_t mode,
    output logic [DW-1:0]     in_q,
    output logic [DW-1:0]     dac_q,
    output logic [DW-1:0]     code
);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] in_nxt;

    // Merge the masked write into the held input value.
    always_comb begin
        in_nxt = we ? ((in_q & ~wmask) | (wdata & wmask)) : in_q;
    end

    // Input rank register.
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= in_nxt;
    end

    // Converter rank register, fed on load or pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n)          dac_q <= '0;
        else if (load || xp) dac_q <= in_nxt;
    end

    // Zero override picks the range-aware zero-volt code.
    always_comb begin
        if (zero_n)        code = dac_q;
        else if (mode.bip) code = MID;
        else               code = '0;
    end

endmodule

// File: rtl/qdf_mode_reg.sv
// Range register for all channels, written as one word from the data bus.
// Assumes 2*NCH bits of write data, two per channel.
module qdf_mode_reg #(
    parameter int NCH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [2*NCH-1:0]   wdata,
    output logic [2*NCH-1:0]   mode_q
);
    // Hold the range entries; a write replaces all of them.
    always_ff @(posedge clk) begin
        if (!rst_n)  mode_q <= '0;
        else if (we) mode_q <= wdata;
    end

endmodule

// File: rtl/qdf_readback.sv
// Readback selector: picks range register or one rank of one channel and
// cuts the requested slice down to the low end of the bus.
// Assumes DW > 2*NCH so the range word fits zero-extended.
module qdf_readback #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    parameter int SW  = 4,
    localparam int CHW = $clog2(NCH),
    localparam int SLW = $clog2(DW / SW + 1)
) (
    input  logic                cs,
    input  logic                rd,
    input  logic [CHW:0]        sel,
    input  logic                rank,
    input  logic [1:0]          wsize,
    input  logic [SLW-1:0]      slice,
    input  logic [NCH*DW-1:0]   in_flat,
    input  logic [NCH*DW-1:0]   dac_flat,
    input  logic [2*NCH-1:0]    mode_flat,
    output logic                rd_oe,
    output logic [DW-1:0]       rd_val
);
    import qdf_pkg::*;

    localparam logic [DW-1:0] NIB_ONES  = {{(DW-SW){1'b0}}, {SW{1'b1}}};
    localparam logic [DW-1:0] BYTE_ONES = {{(DW-2*SW){1'b0}}, {(2*SW){1'b1}}};

    logic [DW-1:0] word;
    logic [DW-1:0] shifted;

    assign rd_oe = cs && rd;

    // Pick the source register for the read.
    always_comb begin
        if (rank) word = dac_flat[int'(sel[CHW-1:0])*DW +: DW];
        else      word = in_flat[int'(sel[CHW-1:0])*DW +: DW];
        shifted = word >> (SW * int'(slice));
    end

    // Cut the slice, or return the range word.
    always_comb begin
        if (sel[CHW]) begin
            rd_val = {{(DW-2*NCH){1'b0}}, mode_flat};
        end else begin
            case (xfer_w_e'(wsize))
                XW_NIB:  rd_val = shifted & NIB_ONES;
                XW_BYTE: rd_val = shifted & BYTE_ONES;
                default: rd_val = word;
            endcase
        end
    end

endmodule

// File: rtl/quad_dac_frontend.sv
// Top of the quad DAC front end: host port decode, four double-ranked
// channels, range register, pass-through select and tristate readback.
// Assumes synchronous active-low reset and an unclocked zero override.
module quad_dac_frontend #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    parameter int SW  = 4,
    localparam int CHW = $clog2(NCH),
    localparam int SLW = $clog2(DW / SW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic              rd,
    input  logic [CHW:0]      sel,
    input  logic [1:0]        wsize,
    input  logic [SLW-1:0]    slice,
    input  logic [DW-1:0]     din,
    input  logic              rd_rank,
    input  logic              ldac,
    input  logic              xparent,
    input  logic              xp_all,
    input  logic [CHW-1:0]    xp_ch,
    input  logic              zero_n,
    output logic [NCH*DW-1:0] dac_code,
    output logic [NCH-1:0]    mode_bip,
    output logic [NCH-1:0]    mode_gain2,
    output logic              rd_oe,
    output logic [DW-1:0]     rd_bus
);
    import qdf_pkg::*;

    logic [NCH-1:0]    ch_we;
    logic              mode_we;
    logic [DW-1:0]     wmask;
    logic [DW-1:0]     wdata;
    logic [2*NCH-1:0]  mode_q;
    logic [NCH*DW-1:0] in_flat;
    logic [NCH*DW-1:0] dac_flat;
    logic [NCH-1:0]    xp_vec;
    logic [DW-1:0]     rd_val;

    qdf_wr_decode #(.NCH(NCH), .DW(DW), .SW(SW)) u_dec (
        .cs      (cs),
        .wr      (wr),
        .sel     (sel),
        .wsize   (wsize),
        .slice   (slice),
        .din     (din),
        .ch_we   (ch_we),
        .mode_we (mode_we),
        .wmask   (wmask),
        .wdata   (wdata)
    );

    qdf_mode_reg #(.NCH(NCH)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mode_we),
        .wdata  (din[2*NCH-1:0]),
        .mode_q (mode_q)
    );

    // Pass-through selection per channel.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            xp_vec[i] = xparent && (xp_all || (xp_ch == CHW'(i)));
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ch_mode_t md;
        assign md            = ch_mode_t'(mode_q[2*g +: 2]);
        assign mode_bip[g]   = md.bip;
        assign mode_gain2[g] = md.gain2;

        qdf_channel #(.DW(DW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (ch_we[g]),
            .wmask  (wmask),
            .wdata  (wdata),
            .load   (ldac),
            .xp     (xp_vec[g]),
            .zero_n (zero_n),
            .mode   (md),
            .in_q   (in_flat[g*DW +: DW]),
            .dac_q  (dac_flat[g*DW +: DW]),
            .code   (dac_code[g*DW +: DW])
        );
    end

    qdf_readback #(.NCH(NCH), .DW(DW), .SW(SW)) u_rb (
        .cs        (cs),
        .rd        (rd),
        .sel       (sel),
        .rank      (rd_rank),
        .wsize     (wsize),
        .slice     (slice),
        .in_flat   (in_flat),
        .dac_flat  (dac_flat),
        .mode_flat (mode_q),
        .rd_oe     (rd_oe),
        .rd_val    (rd_val)
    );

    // Tristate readback driver.
    assign rd_bus = rd_oe ? rd_val : 'z;

endmodule

// File: rtl/qdf_checker.sv
// Port-level properties of the quad DAC front end, bound to the top module.
// Assumes the default register layout of two range bits per channel.
module qdf_checker #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    localparam int CHW = $clog2(NCH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              wr,
    input logic              rd,
    input logic [CHW:0]      sel,
    input logic [2*NCH-1:0]  mdin,
    input logic              ldac,
    input logic              xparent,
    input logic              zero_n,
    input logic [NCH*DW-1:0] dac_code,
    input logic [NCH-1:0]    mode_bip,
    input logic [NCH-1:0]    mode_gain2,
    input logic              rd_oe
);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    logic [2*NCH-1:0] mode_cat;

    // Reassemble the range outputs into register bit order.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            mode_cat[2*i]   = mode_bip[i];
            mode_cat[2*i+1] = mode_gain2[i];
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dac_code == '0 && mode_cat == '0)); // R1

    AST_CODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cs && wr) && !ldac && !xparent && zero_n) |=> (!zero_n || $stable(dac_code))); // R4

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && sel[CHW]) |=> (mode_cat == $past(mdin))); // R7

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs || !rd) |-> !rd_oe); // R10

    for (genvar g = 0; g < NCH; g++) begin : g_z
        AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            !zero_n |-> (dac_code[g*DW +: DW] == (mode_bip[g] ? MID : '0))); // R8
    end

endmodule

bind quad_dac_frontend qdf_checker #(.NCH(NCH), .DW(DW)) u_qdf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (cs),
    .wr         (wr),
    .rd         (rd),
    .sel        (sel),
    .mdin       (din[2*NCH-1:0]),
    .ldac       (ldac),
    .xparent    (xparent),
    .zero_n     (zero_n),
    .dac_code   (dac_code),
    .mode_bip   (mode_bip),
    .mode_gain2 (mode_gain2),
    .rd_oe      (rd_oe)
);

// File: tb/test_quad_dac_frontend.sv
`timescale 1ns/1ps
module test_quad_dac_frontend;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs, wr, rd;
    logic [2:0]  sel;
    logic [1:0]  wsize;
    logic [1:0]  slice;
    logic [11:0] din;
    logic        rd_rank, ldac, xparent, xp_all;
    logic [1:0]  xp_ch;
    logic        zero_n;
    logic [47:0] dac_code;
    logic [3:0]  mode_bip, mode_gain2;
    logic        rd_oe;
    wire  [11:0] rd_bus;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [11:0] m_in [4];
    logic [11:0] m_dac [4];
    logic [7:0]  m_mode;

    always #5 clk = ~clk;

    quad_dac_frontend i_quad_dac_frontend (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .sel(sel),
        .wsize(wsize), .slice(slice), .din(din), .rd_rank(rd_rank),
        .ldac(ldac), .xparent(xparent), .xp_all(xp_all), .xp_ch(xp_ch),
        .zero_n(zero_n), .dac_code(dac_code), .mode_bip(mode_bip),
        .mode_gain2(mode_gain2), .rd_oe(rd_oe), .rd_bus(rd_bus)
    );

    function automatic logic [11:0] f_mask(input logic [1:0] ws, input logic [1:0] sl);
        logic [11:0] m;
        if (ws == 2'd0)      m = 12'h00F << (4 * sl);
        else if (ws == 2'd1) m = 12'h0FF << (4 * sl);
        else                 m = 12'hFFF;
        return m;
    endfunction

    function automatic logic [11:0] f_merge(input logic [11:0] old, input logic [1:0] ws,
                                            input logic [1:0] sl, input logic [11:0] d);
        logic [11:0] m, v;
        m = f_mask(ws, sl);
        v = (ws >= 2'd2) ? d : (d << (4 * sl));
        return (old & ~m) | (v & m);
    endfunction

    function automatic logic [11:0] f_zero_code(input int ch);
        if (zero_n) return m_dac[ch];
        return m_mode[2*ch] ? 12'h800 : 12'h000;
    endfunction

    function automatic logic [11:0] f_rb(input logic [2:0] s, input logic rk,
                                         input logic [1:0] ws, input logic [1:0] sl);
        logic [11:0] v;
        if (s[2]) return {4'h0, m_mode};
        v = rk ? m_dac[s[1:0]] : m_in[s[1:0]];
        if (ws == 2'd0) return (v >> (4 * sl)) & 12'h00F;
        if (ws == 2'd1) return (v >> (4 * sl)) & 12'h0FF;
        return v;
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_codes(input string req);
        for (int i = 0; i < 4; i++) begin
            check(req, 48'(dac_code[i*12 +: 12]), 48'(f_zero_code(i)));
        end
        check(req, 48'({mode_gain2, mode_bip}),
              48'({m_mode[7], m_mode[5], m_mode[3], m_mode[1],
                   m_mode[6], m_mode[4], m_mode[2], m_mode[0]}));
    endtask

    task automatic idle();
        cs = 0; wr = 0; rd = 0; sel = 0; wsize = 0; slice = 0; din = 0;
        rd_rank = 0; ldac = 0; xparent = 0; xp_all = 0; xp_ch = 0;
    endtask

    // One clocked operation; the model follows at the edge.
    task automatic op(input logic c, input logic w, input logic [2:0] s, input logic [1:0] ws,
                      input logic [1:0] sl, input logic [11:0] d, input logic ld,
                      input logic xp, input logic xa, input logic [1:0] xc, input string req);
        logic [11:0] nxt [4];
        @(negedge clk);
        cs = c; wr = w; sel = s; wsize = ws; slice = sl; din = d;
        ldac = ld; xparent = xp; xp_all = xa; xp_ch = xc;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            nxt[i] = m_in[i];
            if (c && w && !s[2] && s[1:0] == 2'(i)) nxt[i] = f_merge(m_in[i], ws, sl, d);
        end
        if (c && w && s[2]) m_mode = d[7:0];
        for (int i = 0; i < 4; i++) begin
            m_in[i] = nxt[i];
            if (ld || (xp && (xa || xc == 2'(i)))) m_dac[i] = nxt[i];
        end
        idle();
        #1;
        chk_codes(req);
    endtask

    task automatic readback(input logic [2:0] s, input logic rk, input logic [1:0] ws,
                            input logic [1:0] sl, input string req);
        @(negedge clk);
        cs = 1; rd = 1; sel = s; rd_rank = rk; wsize = ws; slice = sl;
        #2;
        check(req, 48'(rd_oe), 48'(1));
        check(req, 48'(rd_bus), 48'(f_rb(s, rk, ws, sl)));
        idle();
        #1;
        check("R10", 48'(rd_oe), 48'(0));
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        idle();
        zero_n = 1;
        rst_n = 0;
        for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_dac[i] = 0; end
        m_mode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk_codes("R1");
        for (int i = 0; i < 4; i++) readback(3'(i), 1'b0, 2'd2, 2'd0, "R1");
        check("R10", 48'(rd_oe), 48'(0));

        // R2: word write, no code change without a load
        op(1, 1, 3'd1, 2'd2, 0, 12'hABC, 0, 0, 0, 0, "R2");
        readback(3'd1, 1'b0, 2'd2, 0, "R2");
        readback(3'd0, 1'b0, 2'd2, 0, "R2");
        // R3: nibble and byte pieces, including the empty nibble slot
        op(1, 1, 3'd1, 2'd0, 2'd1, 12'h005, 0, 0, 0, 0, "R3");
        op(1, 1, 3'd1, 2'd0, 2'd3, 12'h00F, 0, 0, 0, 0, "R3");
        op(1, 1, 3'd2, 2'd1, 2'd2, 12'h0E7, 0, 0, 0, 0, "R3");
        readback(3'd1, 1'b0, 2'd2, 0, "R3");
        readback(3'd2, 1'b0, 2'd2, 0, "R3");
        // R4: one load moves all channels, including a same-edge write
        op(1, 1, 3'd3, 2'd2, 0, 12'h123, 1, 0, 0, 0, "R4");
        readback(3'd3, 1'b1, 2'd2, 0, "R4");
        // R5 and R6: pass-through single and all
        op(1, 1, 3'd0, 2'd2, 0, 12'h777, 0, 1, 0, 2'd0, "R5");
        op(1, 1, 3'd2, 2'd2, 0, 12'h0F0, 0, 1, 0, 2'd0, "R5");
        op(1, 1, 3'd2, 2'd1, 2'd0, 12'h0AA, 0, 1, 1, 2'd0, "R6");
        // R7: range write ignores size and slice
        op(1, 1, 3'd4, 2'd0, 2'd3, 12'hF96, 0, 0, 0, 0, "R7");
        readback(3'd4, 1'b0, 2'd0, 2'd2, "R7");
        // R11: unqualified writes change nothing
        op(0, 1, 3'd1, 2'd2, 0, 12'h000, 0, 0, 0, 0, "R11");
        op(1, 0, 3'd4, 2'd2, 0, 12'h000, 0, 0, 0, 0, "R11");
        readback(3'd1, 1'b0, 2'd2, 0, "R11");
        readback(3'd4, 1'b0, 2'd2, 0, "R11");
        // R8: override is unclocked, keeps ranks, releases to old codes
        @(negedge clk);
        zero_n = 0;
        #1;
        chk_codes("R8");
        op(1, 1, 3'd0, 2'd2, 0, 12'h321, 1, 0, 0, 0, "R8");
        @(negedge clk);
        #2;
        zero_n = 1;
        #1;
        chk_codes("R8");

        // Random mix, checked after every operation
        for (int n = 0; n < 400; n++) begin
            int k;
            k = $urandom_range(0, 5);
            case (k)
                0: op(1, 1, 3'($urandom_range(0, 3)), 2'($urandom), 2'($urandom),
                      12'($urandom), 0, 0, 0, 0, "R3");
                1: op(1, 1, 3'($urandom_range(0, 3)), 2'($urandom), 2'($urandom),
                      12'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      2'($urandom), "R5");
                2: op(1, 1, 3'd4, 2'($urandom), 2'($urandom), 12'($urandom),
                      0, 0, 0, 0, "R7");
                3: op(1'($urandom), 1'($urandom), 3'($urandom), 2'($urandom),
                      2'($urandom), 12'($urandom), 1, 0, 0, 0, "R4");
                4: readback(3'($urandom_range(0, 4)), 1'($urandom), 2'($urandom),
                            2'($urandom), "R9");
                default: begin
                    @(negedge clk);
                    zero_n = 0;
                    #1;
                    chk_codes("R8");
                    zero_n = 1;
                    #1;
                    chk_codes("R8");
                end
            endcase
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule